// File: doc/BRIEF.md
# Two-Branch Half-Band Allpass Lowpass Filter

This block is a full-rate, fixed-point half-band lowpass IIR filter. It adds the outputs of two allpass branches and halves the sum. The upper branch runs the input through a cascade of second-order allpass sections. The lower branch first delays the input by one sample and then runs it through its own cascade of the same length. Each section uses one multiplier. With one section per branch the response is fifth order, from only two multiplies per sample.

The filter takes one signed sample each time `en` is high, and it returns one filtered sample per strobe, flagged by a registered `valid_out`. The input is widened inside the block: sign-extension guard bits go above the data, and zero fraction bits go below it. This leaves headroom at the pre-subtraction node, where the gain can reach two. The output is rounded back to the input width plus one guard bit. Coefficients are signed 18-bit fractions held on input ports, so they can be changed at run time.

Top module: `halfband_ap_lpf`

## Requirements
- R1: A synchronous active-high `rst` clears every delay register, `dout` and `valid_out`. After reset, an all-zero input stream gives all-zero outputs.
- R2: Each input is sign-extended by GUARD bits and shifted left by FRAC bits into a DW = IN_W+GUARD+FRAC bit word (24 bits by default). With zero coefficients, a constant input d settles to the output value d.
- R3: Each section computes y(n) = x(n-2) + floor(c·(x(n) − y(n-2)) / 2^17). Here c is the signed 18-bit coefficient, read as c/2^17.
- R4: The output for sample k is built from w0(k) + w1(k). Here w0 is the upper cascade applied to x, and w1 is the lower cascade applied to x delayed by one sample (zero before the first sample).
- R5: With s = w0+w1, the output is floor(s/2^(FRAC+1)) plus bit FRAC of s, given as IN_W+GUARD bits in two's complement. With zero coefficients, an input of +1 gives 1 and an input of −1 gives 0.
- R6: The output for the strobe with index k (counted from 0 after reset) appears after strobe k+NSEC+1. `valid_out` is high for exactly the cycle after each strobe that has such an output.
- R7: While `en` is low, no register changes, `dout` holds and `valid_out` is low. Any `din` value seen in those cycles has no effect on later outputs.
- R8: Coefficient section i of a branch is taken from bits [18·i +: 18] of `coef_up` or `coef_dn`. Section 0 is the first in the cascade. A new set that is loaded and followed by a reset gives the response of that set.
- R9: Full-scale steps between +32767 and −32768 pass through without any wrap of the section or output arithmetic.
- R10: Every section adds one strobe of latency in both branches. With zero coefficients and NSEC sections, an impulse of height d appears as d/2 at output samples 2·NSEC and 2·NSEC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample strobe; gates every register |
| din | input | IN_W | Signed input sample |
| coef_up | input | NSEC·COEF_W | Upper-branch section coefficients, section 0 in low bits |
| coef_dn | input | NSEC·COEF_W | Lower-branch (delayed) section coefficients |
| dout | output | IN_W+GUARD | Rounded, halved filter output |
| valid_out | output | 1 | High for one cycle when `dout` holds a new sample |

## Verification
A zero-coefficient impulse turns every section into a pure two-sample delay. This exposes the one-sample offset of the lower branch, the per-section latency and the halving. Checking ±1 impulses against hand-worked values tells correct rounding apart from plain truncation. Long random streams with two different nonzero coefficient sets are compared bit for bit against an integer model, which catches errors in the feedback, in the floor scaling or in the coefficient slicing. A repeated full-scale step probes the headroom, and gaps with changing `din` while `en` is low, plus a reset in mid-stream, show that idle cycles and reset leave no trace.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  // Internal data width: guard bits above, fraction bits below the sample.
  function automatic int data_width(input int in_w, input int guard, input int frac);
    return in_w + guard + frac;
  endfunction

  // Width of the strobe counter that tracks pipeline fill.
  function automatic int fill_width(input int lat);
    return $clog2(lat + 1);
  endfunction
endpackage

// File: rtl/hbf_align.sv
module hbf_align #(
  parameter int IN_W  = 16,
  parameter int GUARD = 1,
  parameter int FRAC  = 7,
  localparam int DW   = hbf_pkg::data_width(IN_W, GUARD, FRAC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [IN_W-1:0] din,
  output logic signed [DW-1:0]   x_o
);
  logic signed [DW-1:0] widened;

  assign widened = DW'(din) <<< FRAC;

  always_ff @(posedge clk) begin
    if (rst)     x_o <= '0;
    else if (en) x_o <= widened;
  end
endmodule

// File: rtl/hbf_ap_section.sv
module hbf_ap_section #(
  parameter int DW     = 24,
  parameter int COEF_W = 18,
  parameter int CFRAC  = 17,
  localparam int PW    = DW + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [DW-1:0]     x_i,
  output logic signed [DW-1:0]     y_o
);
  logic signed [DW-1:0] x1, x2, y2;
  logic signed [DW:0]   diff;
  logic signed [PW-1:0] prod, scaled, yfull;

  // pre-subtraction keeps one extra bit: the gain there may reach two
  assign diff   = (DW+1)'(x_i) - (DW+1)'(y2);
  assign prod   = PW'(diff) * PW'(coef);
  assign scaled = prod >>> CFRAC;
  assign yfull  = PW'(x2) + scaled;

  // feedback loop: y_o then y2, so the multiply is not registered in the loop
  always_ff @(posedge clk) begin
    if (rst) begin
      x1  <= '0;
      x2  <= '0;
      y2  <= '0;
      y_o <= '0;
    end else if (en) begin
      x1  <= x_i;
      x2  <= x1;
      y2  <= y_o;
      y_o <= yfull[DW-1:0];
    end
  end

  // R7: an idle cycle leaves the section output untouched
  a_r7_section_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_o));

  // R3: a zero coefficient reduces the section to a two-sample delay
  a_r3_zero_coef: assert property (@(posedge clk) disable iff (rst)
    (en && coef == '0) |=> (y_o == $past(x2)));

  // R9: the section sum never needs more than DW bits
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    en |-> (yfull[PW-1:DW-1] == '0 || yfull[PW-1:DW-1] == '1));
endmodule

// File: rtl/hbf_branch.sv
module hbf_branch #(
  parameter int NSEC   = 2,
  parameter int LEAD   = 0,
  parameter int DW     = 24,
  parameter int COEF_W = 18,
  parameter int CFRAC  = 17,
  localparam int CV_W  = NSEC * COEF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [CV_W-1:0]        coefs,
  input  logic signed [DW-1:0]   x_i,
  output logic signed [DW-1:0]   y_o
);
  logic signed [DW-1:0] chain [NSEC+1];

  generate
    if (LEAD != 0) begin : g_lead
      logic signed [DW-1:0] xd;
      always_ff @(posedge clk) begin
        if (rst)     xd <= '0;
        else if (en) xd <= x_i;
      end
      assign chain[0] = xd;
    end else begin : g_nolead
      assign chain[0] = x_i;
    end

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
      hbf_ap_section #(.DW(DW), .COEF_W(COEF_W), .CFRAC(CFRAC)) u_sec (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .coef (coefs[s*COEF_W +: COEF_W]),
        .x_i  (chain[s]),
        .y_o  (chain[s+1])
      );
    end
  endgenerate

  assign y_o = chain[NSEC];
endmodule

// File: rtl/hbf_out_round.sv
module hbf_out_round #(
  parameter int DW    = 24,
  parameter int SHIFT = 8,
  localparam int OUT_W = DW + 1 - SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [DW-1:0]    a,
  input  logic signed [DW-1:0]    b,
  output logic signed [OUT_W-1:0] dout
);
  logic signed [DW:0] sum, rnd;

  assign sum = (DW+1)'(a) + (DW+1)'(b);
  // halving and the return to the input scale share one shift; the bit just below the LSB rounds
  assign rnd = (sum >>> SHIFT) + (DW+1)'($signed({1'b0, sum[SHIFT-1]}));

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (en) dout <= rnd[OUT_W-1:0];
  end

  // R9: the rounded result always fits the output word
  a_r9_out_range: assert property (@(posedge clk) disable iff (rst)
    en |-> (rnd[DW:OUT_W-1] == '0 || rnd[DW:OUT_W-1] == '1));
endmodule

// File: rtl/halfband_ap_lpf.sv
module halfband_ap_lpf #(
  parameter int IN_W   = 16,
  parameter int GUARD  = 1,
  parameter int FRAC   = 7,
  parameter int NSEC   = 2,
  parameter int COEF_W = 18,
  parameter int CFRAC  = 17,
  localparam int DW    = hbf_pkg::data_width(IN_W, GUARD, FRAC),
  localparam int OUT_W = IN_W + GUARD,
  localparam int CV_W  = NSEC * COEF_W,
  localparam int LAT   = NSEC + 1,
  localparam int CNT_W = hbf_pkg::fill_width(LAT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  din,
  input  logic [CV_W-1:0]         coef_up,
  input  logic [CV_W-1:0]         coef_dn,
  output logic signed [OUT_W-1:0] dout,
  output logic                    valid_out
);
  logic signed [DW-1:0] x_al, w_up, w_dn;
  logic [CNT_W-1:0]     fill;

  hbf_align #(.IN_W(IN_W), .GUARD(GUARD), .FRAC(FRAC)) u_align (
    .clk (clk), .rst (rst), .en (en), .din (din), .x_o (x_al)
  );

  hbf_branch #(.NSEC(NSEC), .LEAD(0), .DW(DW), .COEF_W(COEF_W), .CFRAC(CFRAC)) u_up (
    .clk (clk), .rst (rst), .en (en), .coefs (coef_up), .x_i (x_al), .y_o (w_up)
  );

  // the lower branch's z^-1 is folded into the branch as a lead register
  hbf_branch #(.NSEC(NSEC), .LEAD(1), .DW(DW), .COEF_W(COEF_W), .CFRAC(CFRAC)) u_dn (
    .clk (clk), .rst (rst), .en (en), .coefs (coef_dn), .x_i (x_al), .y_o (w_dn)
  );

  hbf_out_round #(.DW(DW), .SHIFT(FRAC + 1)) u_round (
    .clk (clk), .rst (rst), .en (en), .a (w_up), .b (w_dn), .dout (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= en && (fill == CNT_W'(LAT));
      if (en && fill != CNT_W'(LAT)) fill <= fill + 1'b1;
    end
  end

  // R1: reset empties the output stage
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dout == '0 && !valid_out));

  // R7: an idle cycle changes nothing at the output
  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && !valid_out));

  // R6: a valid flag only ever follows a strobe
  a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> $past(en));
endmodule

// File: tb/test_halfband_ap_lpf.sv
module test_halfband_ap_lpf;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 16, GUARD = 1, FRAC = 7, NSEC = 2, COEF_W = 18, CFRAC = 17;
  localparam int DW = IN_W + GUARD + FRAC, OUT_W = IN_W + GUARD, LAT = NSEC + 1;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic signed [IN_W-1:0]  din = '0;
  logic [NSEC*COEF_W-1:0]  coef_up = '0, coef_dn = '0;
  logic signed [OUT_W-1:0] dout;
  logic valid_out;

  halfband_ap_lpf #(.IN_W(IN_W), .GUARD(GUARD), .FRAC(FRAC), .NSEC(NSEC),
                    .COEF_W(COEF_W), .CFRAC(CFRAC)) i_halfband_ap_lpf (
    .clk(clk), .rst(rst), .en(en), .din(din), .coef_up(coef_up), .coef_dn(coef_dn),
    .dout(dout), .valid_out(valid_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int     cset [2][NSEC];
  longint mx1 [2][NSEC], mx2 [2][NSEC], my1 [2][NSEC], my2 [2][NSEC];
  longint xprev;
  longint exp_q [$];
  string  tag_q [$];

  task automatic check(input bit ok, input string tag, input longint got, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic load_coefs(input int u0, input int u1, input int d0, input int d1);
    cset[0][0] = u0; cset[0][1] = u1; cset[1][0] = d0; cset[1][1] = d1;
    for (int s = 0; s < NSEC; s++) begin
      coef_up[s*COEF_W +: COEF_W] = COEF_W'(cset[0][s]);
      coef_dn[s*COEF_W +: COEF_W] = COEF_W'(cset[1][s]);
    end
  endtask

  function automatic void model_clear();
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NSEC; s++) begin
        mx1[b][s] = 0; mx2[b][s] = 0; my1[b][s] = 0; my2[b][s] = 0;
      end
    xprev = 0;
  endfunction

  // R3 section recurrence, R9 range guard
  function automatic longint sec_step(input int b, input int s, input longint u);
    longint y;
    y = mx2[b][s] + ((longint'(cset[b][s]) * (u - my2[b][s])) >>> CFRAC);
    if (y >= (64'sd1 <<< (DW-1)) || y < -(64'sd1 <<< (DW-1))) begin
      checks++; errors++;
      $display("FAIL R9 section value %0d outside %0d-bit range (expected in range)", y, DW);
    end
    mx2[b][s] = mx1[b][s]; mx1[b][s] = u;
    my2[b][s] = my1[b][s]; my1[b][s] = y;
    return y;
  endfunction

  // R2 alignment, R4 branch sum, R5 rounding
  function automatic longint model_step(input longint d);
    longint xa, u0, u1, s;
    xa = d <<< FRAC;
    u0 = xa; u1 = xprev; xprev = xa;
    for (int k = 0; k < NSEC; k++) begin
      u0 = sec_step(0, k, u0);
      u1 = sec_step(1, k, u1);
    end
    s = u0 + u1;
    return (s >>> (FRAC+1)) + ((s >>> FRAC) & 1);
  endfunction

  // driver: called at a falling edge, returns at the next one
  task automatic strobe(input int d, input string tag);
    din = IN_W'(d);
    en  = 1'b1;
    exp_q.push_back(model_step(longint'(d)));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    en = 1'b0;
    for (int i = 0; i < n; i++) begin
      din = IN_W'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    en = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    exp_q.delete(); tag_q.delete();
    check(dout == '0, "R1 dout after reset", longint'(dout), 0);
    check(valid_out == 1'b0, "R1 valid after reset", longint'(valid_out), 0);
  endtask

  function automatic int rnd_sample(input int span);
    return int'($urandom_range(0, 2*span - 1)) - span;
  endfunction

  // monitor: pops the scoreboard on each valid output
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 valid with no pending sample", 1, 0);
      end else begin
        longint e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(longint'(dout) == e, t, longint'(dout), e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    load_coefs(0, 0, 0, 0);
    model_clear();
    do_reset();

    // R6 + R10: impulse through zero-coefficient cascades, hand-worked values
    for (int j = 0; j < 12; j++) begin
      longint ev;
      strobe(j == 0 ? 1000 : 0, "R4 impulse");
      check(valid_out == (j >= LAT), "R6 valid timing", longint'(valid_out), longint'(j >= LAT));
      ev = (j - LAT == 2*NSEC || j - LAT == 2*NSEC + 1) ? 500 : 0;
      if (j >= LAT) check(longint'(dout) == ev, "R10 impulse position", longint'(dout), ev);
    end
    // R5 rounding of the smallest inputs: +1 -> 1, -1 -> 0
    for (int j = 0; j < 10; j++) strobe(j == 0 ? 1 : 0, "R5 plus one");
    check(longint'(dout) == 0, "R5 settle", longint'(dout), 0);
    strobe(-1, "R5 minus one");
    for (int j = 0; j < 9; j++) begin
      strobe(0, "R5 minus one");
      if (j == 2*NSEC) check(longint'(dout) == 0, "R5 minus one rounds to 0", longint'(dout), 0);
    end
    // R2 constant input settles to itself
    for (int j = 0; j < 12; j++) strobe(1234, "R2 step");
    check(longint'(dout) == 1234, "R2 steady level", longint'(dout), 1234);
    idle(2);

    // R3: random stream with the main coefficient set
    load_coefs(18088, 16384, 76638, 73728);
    do_reset();
    for (int j = 0; j < 300; j++) strobe(rnd_sample(16384), "R3 random");
    // R7: idle cycles with changing din must leave no trace
    begin
      logic signed [OUT_W-1:0] held;
      held = dout;
      en = 1'b0;
      for (int i = 0; i < 6; i++) begin
        din = IN_W'($urandom);
        @(negedge clk);
        check(dout == held, "R7 dout held", longint'(dout), longint'(held));
        check(valid_out == 1'b0, "R7 valid low", longint'(valid_out), 0);
      end
    end
    for (int j = 0; j < 60; j++) begin
      strobe(rnd_sample(16384), "R7 after gap");
      if (j % 7 == 3) idle(3);
    end

    // R9: full-scale steps
    for (int j = 0; j < 60; j++) strobe(32767, "R9 full scale");
    for (int j = 0; j < 60; j++) strobe(-32768, "R9 full scale");
    for (int j = 0; j < 40; j++) strobe(32767, "R9 full scale");
    for (int j = 0; j < 40; j++) strobe(j % 2 == 0 ? 32767 : -32768, "R9 alternate");

    // R8: a different coefficient set loaded at run time
    idle(2);
    load_coefs(24576, 28672, 86016, 91136);
    do_reset();
    for (int j = 0; j < 250; j++) strobe(rnd_sample(30000), "R8 second set");

    // R1: reset in mid-stream, then silence must stay silent
    do_reset();
    for (int j = 0; j < 20; j++) strobe(0, "R1 cleared history");
    idle(LAT + 2);

    check(exp_q.size() <= LAT, "R6 pending samples", longint'(exp_q.size()), LAT);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule